// File: doc/BRIEF.md
# Framed Serial Word Receiver with Early-Sync Handling

This block takes a serial data line and a frame sync line, both sampled on the block clock, which serves as the bit clock. When a frame sync pulse is accepted, the block waits a programmable number of bit clocks, from zero to two. It then shifts in a fixed-length word, most significant bit first. When the last bit arrives, the block presents the assembled word with a one-cycle valid strobe.

Each accepted frame sync opens a protection window that lasts for the length of one word. A frame sync pulse that lands inside this window is early, and a control input decides what happens to it:
- **Ignore mode:** the pulse is ignored completely.
- **Abort mode:** the word being assembled is thrown away and a sticky synchronization error flag is set. Reception restarts from the offending pulse, as though it were a normal frame start.

The flag stays set until a dedicated clear input is pulsed.

Top module: `frame_rx_engine`

## Requirements
- R1: While reset is held low at a clock edge, `word_valid_o` is 0, `sync_err_o` is 0 and `word_o` is 0 after that edge.
- R2: `delay_code_i` selects the data delay d: code 0 gives d=0, code 1 gives d=1, code 2 gives d=2, and code 3 behaves like code 2. The first data bit is the value of `sdata_i` sampled d clock edges after the edge that samples an accepted frame sync.
- R3: A word is WORD_W bits long and the first bit received ends up in `word_o[WORD_W-1]`. `word_valid_o` is high for exactly the one cycle following the edge that samples the last bit, and `word_o` carries the word in that cycle.
- R4: A frame sync sampled WORD_W or more edges after the last accepted frame sync, or with no earlier accepted sync since reset, is a normal frame start and never sets `sync_err_o`.
- R5: A frame sync sampled 1 to WORD_W-1 edges after the last accepted frame sync is early.
- R6: With `ignore_early_i`=1, an early frame sync has no effect. The word in progress is delivered intact, `sync_err_o` does not change, and the protection window keeps its original timing.
- R7: With `ignore_early_i`=0, an early frame sync discards the partially received word, and that word is never presented. This also applies when its last bit is sampled on the same edge as the early sync.
- R8: With `ignore_early_i`=0, an early frame sync sets `sync_err_o` to 1 after that edge. Once set, the flag stays at 1 until it is cleared.
- R9: An early frame sync that is not ignored starts a new frame. The next word is taken d bit clocks after it and delivered normally.
- R10: `err_clear_i` sampled high clears `sync_err_o` after that edge. If a non-ignored early frame sync is sampled on the same edge, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync_i | input | 1 | Frame sync pulse, one cycle wide |
| sdata_i | input | 1 | Serial data line |
| delay_code_i | input | 2 | Data delay selection (0, 1, 2; 3 acts as 2) |
| ignore_early_i | input | 1 | 1: early frame syncs are ignored; 0: they abort and restart |
| err_clear_i | input | 1 | Clears the sticky synchronization error flag |
| word_o | output | WORD_W | Last completed word, MSB received first |
| word_valid_o | output | 1 | One-cycle strobe marking a new word on `word_o` |
| sync_err_o | output | 1 | Sticky synchronization error flag |

## Verification
Back-to-back streams, with each sync exactly one word length after the previous one, are run with every delay code and both ignore settings. They show that a sync on the window boundary is a clean start, and that the delay shifts the word boundary by the right number of bits. Streams with gaps of three idle clocks show that idle time adds no bits.

An early sync is then placed at every offset from 1 to WORD_W-1 for each delay and both ignore settings. In abort mode this separates the discarded word from the restarted word, including the offset where the discarded word's last bit coincides with the sync. In ignore mode, a normal sync placed at the original window end shows that the ignored pulse did not move the window. Clear-alone and clear-together-with-set sequences tell the sticky flag's priority apart.

// File: rtl/frx_pkg.sv
// Package: shared definitions for the framed serial receiver.
// Holds the delay-code width and the mapping from code to bit clocks.
package frx_pkg;

    localparam int unsigned DLY_CODE_W = 2;

    typedef logic [DLY_CODE_W-1:0] dly_code_t;

    // Map a delay code to the number of bit clocks; the spare code acts as the largest delay.
    function automatic dly_code_t delay_cycles(input dly_code_t code);
        return (code == dly_code_t'(3)) ? dly_code_t'(2) : code;
    endfunction

endpackage

// File: rtl/frx_sync_window.sv
// Module: frx_sync_window
// Tracks the protection window after each accepted frame sync. It
// classifies incoming pulses as normal or early, decides between start and
// abort, and owns the sticky synchronization error flag.
// Assumes: fsync_i is a single-cycle pulse; WORD_W >= 2.
module frx_sync_window #(
    parameter int unsigned WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync_i,
    input  logic ignore_i,
    input  logic clr_i,
    output logic start_o,
    output logic abort_o,
    output logic err_o
);

    localparam int unsigned CW = $clog2(WORD_W);

    logic [CW-1:0] win_cnt;
    logic          early;

    // Classify the current pulse and decide start or abort.
    always_comb begin
        early   = fsync_i && (win_cnt != '0);
        abort_o = early && !ignore_i;
        start_o = fsync_i && (!early || !ignore_i);
    end

    // Count down the edges left in the window opened by the last accepted sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (start_o) begin
            win_cnt <= CW'(WORD_W - 1);
        end else if (win_cnt != '0) begin
            win_cnt <= win_cnt - 1'b1;
        end
    end

    // Sticky error flag: an abort sets it, the clear input resets it, and set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (abort_o) begin
            err_o <= 1'b1;
        end else if (clr_i) begin
            err_o <= 1'b0;
        end
    end

endmodule

// File: rtl/frx_delay_line.sv
// Module: frx_delay_line
// Counts the programmed data delay after a frame start and marks the
// cycle in which the first data bit is on the line.
// Assumes: a new start always overrides a delay still counting.
module frx_delay_line (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  frx_pkg::dly_code_t code_i,
    output logic               first_o
);

    frx_pkg::dly_code_t dly;
    frx_pkg::dly_code_t pend_cnt;

    // Resolve the code and flag the first-bit cycle.
    always_comb begin
        dly     = frx_pkg::delay_cycles(code_i);
        first_o = start_i ? (dly == '0) : (pend_cnt == frx_pkg::dly_code_t'(1));
    end

    // Load the delay on a start, then count down to the first-bit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cnt <= '0;
        end else if (start_i) begin
            pend_cnt <= dly;
        end else if (pend_cnt != '0) begin
            pend_cnt <= pend_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/frx_shifter.sv
// Module: frx_shifter
// Assembles WORD_W serial bits, MSB first, and publishes the word with a
// one-cycle strobe. An abort drops the partial word; a first-bit mark
// takes priority over an abort in the same cycle.
// Assumes: first_i never hits while a word is still assembling unless
// abort_i is also high (guaranteed by the window logic); WORD_W >= 2.
module frx_shifter #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_i,
    input  logic              abort_i,
    input  logic              sdata_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);

    localparam int unsigned CW = $clog2(WORD_W);

    logic [WORD_W-1:0] sh_reg;
    logic [CW-1:0]     bit_cnt;
    logic              busy;
    logic [WORD_W-1:0] next_sh;

    // Next shift register value with the new bit at the bottom.
    always_comb begin
        next_sh = {sh_reg[WORD_W-2:0], sdata_i};
    end

    // Shift bits in, drop on abort, and publish the word on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_reg  <= '0;
            bit_cnt <= '0;
            busy    <= 1'b0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (first_i) begin
                sh_reg  <= {{(WORD_W-1){1'b0}}, sdata_i};
                bit_cnt <= CW'(1);
                busy    <= 1'b1;
            end else if (abort_i) begin
                sh_reg  <= '0;
                bit_cnt <= '0;
                busy    <= 1'b0;
            end else if (busy) begin
                sh_reg <= next_sh;
                if (bit_cnt == CW'(WORD_W - 1)) begin
                    word_o  <= next_sh;
                    valid_o <= 1'b1;
                    busy    <= 1'b0;
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/frame_rx_engine.sv
// Module: frame_rx_engine (top)
// Framed serial receiver. It delays by a programmable count after frame
// sync, assembles a fixed-length word and presents it with a valid strobe.
// An early frame sync is either ignored or aborts the word, sets a sticky
// error and restarts.
// Assumes: the clock is the bit clock; fsync_i pulses last one cycle.
module frame_rx_engine #(
    parameter int unsigned WORD_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             fsync_i,
    input  logic                             sdata_i,
    input  logic [frx_pkg::DLY_CODE_W-1:0]   delay_code_i,
    input  logic                             ignore_early_i,
    input  logic                             err_clear_i,
    output logic [WORD_W-1:0]                word_o,
    output logic                             word_valid_o,
    output logic                             sync_err_o
);

    logic start_w;
    logic abort_w;
    logic first_w;

    frx_sync_window #(.WORD_W(WORD_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync_i  (fsync_i),
        .ignore_i (ignore_early_i),
        .clr_i    (err_clear_i),
        .start_o  (start_w),
        .abort_o  (abort_w),
        .err_o    (sync_err_o)
    );

    frx_delay_line u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .code_i  (delay_code_i),
        .first_o (first_w)
    );

    frx_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_i (first_w),
        .abort_i (abort_w),
        .sdata_i (sdata_i),
        .word_o  (word_o),
        .valid_o (word_valid_o)
    );

endmodule

// File: rtl/frx_checker.sv
// Module: frx_checker
// Temporal properties of the framed receiver, attached through bind.
module frx_checker (
    input logic clk,
    input logic rst_n,
    input logic fsync_i,
    input logic ignore_early_i,
    input logic err_clear_i,
    input logic abort_i,
    input logic word_valid_o,
    input logic sync_err_o
);

    // R3: the strobe lasts a single cycle
    a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    // R8: the flag holds without a clear
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_o && !err_clear_i |=> sync_err_o);

    // R8: the flag only rises after a frame sync
    a_r8_err_needs_fsync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err_o) |-> $past(fsync_i));

    // R6: ignore mode never raises the flag
    a_r6_ignore_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err_o) |-> !$past(ignore_early_i));

    // R10: a clear without a competing sync empties the flag
    a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear_i && !fsync_i |=> !sync_err_o);

    // R7: an abort is never followed by a delivered word
    a_r7_abort_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !word_valid_o);

endmodule

bind frame_rx_engine frx_checker u_frx_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fsync_i        (fsync_i),
    .ignore_early_i (ignore_early_i),
    .err_clear_i    (err_clear_i),
    .abort_i        (abort_w),
    .word_valid_o   (word_valid_o),
    .sync_err_o     (sync_err_o)
);

// File: tb/frame_rx_engine_bench.sv
module frame_rx_engine_bench;

    localparam int W = 8;
    localparam int N = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fsync = 1'b0;
    logic         sdata = 1'b0;
    logic [1:0]   dcode = 2'd0;
    logic         ign = 1'b0;
    logic         eclr = 1'b0;
    logic [W-1:0] word;
    logic         valid;
    logic         serr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic         fs_s  [0:N-1];
    logic         dt_s  [0:N-1];
    logic         clr_s [0:N-1];
    logic         exp_v [0:N-1];
    logic [W-1:0] exp_w [0:N-1];
    logic         exp_e [0:N-1];

    always #10 clk = ~clk;

    frame_rx_engine #(.WORD_W(W)) u_frame_rx_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .fsync_i        (fsync),
        .sdata_i        (sdata),
        .delay_code_i   (dcode),
        .ignore_early_i (ign),
        .err_clear_i    (eclr),
        .word_o         (word),
        .word_valid_o   (valid),
        .sync_err_o     (serr)
    );

    function automatic logic [W-1:0] pat(input int seed);
        return W'((seed * 29 + 60) ^ 8'hA5);
    endfunction

    function automatic int dly_of(input int code);
        return (code == 3) ? 2 : code;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_sched();
        for (int i = 0; i < N; i++) begin
            fs_s[i] = 0; dt_s[i] = 0; clr_s[i] = 0;
            exp_v[i] = 0; exp_w[i] = '0; exp_e[i] = 0;
        end
    endtask

    // Frame sync at t, bits from t+d, valid expected after the last bit edge.
    task automatic place_word(input int t, input int d, input logic [W-1:0] w, input bit expect_it);
        fs_s[t] = 1;
        for (int i = 0; i < W; i++) dt_s[t + d + i] = w[W-1-i];
        if (expect_it) begin
            exp_v[t + d + W - 1] = 1;
            exp_w[t + d + W - 1] = w;
        end
    endtask

    task automatic err_from(input int n, input logic v);
        for (int m = n; m < N; m++) exp_e[m] = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; fsync = 0; sdata = 0; eclr = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R1 valid", W'(valid), '0);
        chk("R1 err", W'(serr), '0);
        chk("R1 word", word, '0);
        rst_n = 1;
    endtask

    task automatic run_scn(input int code, input bit ig, input string tag);
        dcode = 2'(code);
        ign   = ig;
        do_reset();
        fsync = fs_s[0]; sdata = dt_s[0]; eclr = clr_s[0];
        for (int n = 0; n < N; n++) begin
            @(negedge clk);
            chk({tag, " valid"}, W'(valid), W'(exp_v[n]));
            if (exp_v[n]) chk({tag, " word"}, word, exp_w[n]);
            chk({tag, " err"}, W'(serr), W'(exp_e[n]));
            if (n + 1 < N) begin
                fsync = fs_s[n+1]; sdata = dt_s[n+1]; eclr = clr_s[n+1];
            end else begin
                fsync = 0; sdata = 0; eclr = 0;
            end
        end
    endtask

    initial begin
        int d;
        // R2 R3 R4: back-to-back frames, every code incl. the spare code, both modes
        for (int code = 0; code < 4; code++) begin
            for (int ig = 0; ig < 2; ig++) begin
                d = dly_of(code);
                clear_sched();
                for (int k = 0; k < 3; k++) place_word(2 + k * W, d, pat(code * 7 + k + ig), 1);
                run_scn(code, ig[0], (code == 3) ? "R2 R4 spare" : "R2 R3 R4 stream");
            end
        end
        // R3 R4: gaps between frames
        for (int code = 0; code < 3; code++) begin
            d = dly_of(code);
            clear_sched();
            for (int k = 0; k < 3; k++) place_word(2 + k * (W + 3), d, pat(40 + code + k), 1);
            run_scn(code, 1'b0, "R3 R4 gap");
        end
        // R5 R6 R7 R8 R9: early sync at every offset
        for (int code = 0; code < 3; code++) begin
            for (int k = 1; k < W; k++) begin
                d = dly_of(code);
                clear_sched();
                place_word(2, d, pat(k + code * 11), 1);
                fs_s[2 + k] = 1;
                place_word(2 + W, d, pat(90 + k), 1);
                run_scn(code, 1'b1, "R5 R6 ignored");
                clear_sched();
                place_word(2, d, pat(k + code * 11), 0);
                place_word(2 + k, d, pat(70 + k), 1);
                err_from(2 + k, 1);
                run_scn(code, 1'b0, "R5 R7 R8 R9 abort");
            end
        end
        // R10: clear alone, then clear together with an aborting sync
        clear_sched();
        place_word(2, 1, pat(3), 0);
        place_word(5, 1, pat(4), 1);
        err_from(5, 1);
        clr_s[20] = 1;
        err_from(20, 0);
        run_scn(1, 1'b0, "R10 clear");
        clear_sched();
        place_word(2, 1, pat(5), 0);
        place_word(5, 1, pat(6), 1);
        clr_s[5] = 1;
        err_from(5, 1);
        clr_s[25] = 1;
        err_from(25, 0);
        run_scn(1, 1'b0, "R10 set wins");

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule